// File: doc/BRIEF.md
# Reloadable Periodic Interval Timer

This block raises a periodic interrupt for a processor. Software picks the period by writing a 9-bit reload value through a 32-bit register port. The period is derived in two steps. First an event rate is formed as `EVENTS_NUM / (reload + 1)` in whole events per second, with integer truncation. The period is then one second divided by that rate, in whole microseconds, again truncated.

A prescaler divides the input clock down to a one-microsecond tick. A period counter counts those ticks. At the end of each period the interrupt output goes high and the next period starts at once, so the timer runs freely. Software acknowledges the interrupt by reading a count register, which always reads as zero. Writing a new reload value drops the interrupt and restarts timing from the write.

Top module: `ivt_timer`

## Requirements
- R1: A write to word offset 0x228 keeps only bits 8:0 of the write data as the reload value. Bits 31:9 have no effect on the period.
- R2: Address bits 1:0 are ignored when decoding. A write to 0x22B acts exactly like a write to 0x228.
- R3: The period in clock cycles is `CLK_PER_US * (US_PER_SEC / (EVENTS_NUM / (reload + 1)))`, with integer division at each step.
- R4: A reload write drops `irq_o` on the clock edge that takes the write, even if `irq_o` was high. Counting restarts from that edge, so the first interrupt after it comes one full new period later and the old schedule is discarded.
- R5: `irq_o` rises exactly one period after the start of timing. The timer then continues with no software action, so rise k comes k periods after the start.
- R6: A read of offset 0x230 returns zero on `bus_rdata_o` and drops `irq_o` on the edge that takes the read.
- R7: When an acknowledge read and a period expiry fall on the same clock edge, the expiry wins and `irq_o` is high after that edge.
- R8: During reset `irq_o` is low. After reset the reload value is 0, so the first interrupt comes `CLK_PER_US * (US_PER_SEC / EVENTS_NUM)` cycles after the internal reset is released.
- R9: Accesses to other offsets have no effect. A write to 0x22C neither changes the period nor restarts it, and a read of 0x234 does not clear `irq_o`. Every read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fixed-frequency clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, always zero |
| irq_o | output | 1 | Periodic interrupt, level |

## Verification
The bench builds the timer with `CLK_PER_US = 2`, `US_PER_SEC = 10000` and `EVENTS_NUM = 1000`. With these values the shortest period is 20 cycles and the longest is 20,000 cycles. That brings the full reload range within reach, including the truncation step between reload 499 (rate 2) and reload 511 (rate 1).

The short periods also make it possible to place an acknowledge read on exactly the expiry edge. A reload write can likewise land in the middle of a running period. Every interrupt rise is compared against the cycle that the period formula predicts.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  localparam int unsigned RELOAD_W      = 9;
  localparam int unsigned DATA_W        = 32;
  localparam int unsigned OFS_RELOAD    = 32'h228;
  localparam int unsigned OFS_ACK_COUNT = 32'h230;

  // Period in microseconds for a given reload value: rate is truncated
  // events per second, period is truncated microseconds per event.
  function automatic logic [31:0] ivt_period_us(input logic [RELOAD_W-1:0] reload,
                                                input int unsigned ev_num,
                                                input int unsigned us_sec);
    logic [31:0] rate;
    logic [31:0] per;
    rate = ev_num / (32'(reload) + 32'd1);
    if (rate == 32'd0) per = us_sec;
    else               per = us_sec / rate;
    if (per == 32'd0)  per = 32'd1;
    return per;
  endfunction

endpackage

// File: rtl/ivt_rst_sync.sv
module ivt_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
  parameter int unsigned CLK_PER_US = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);

  generate
    if (CLK_PER_US <= 1) begin : g_bypass
      logic unused_restart;
      assign unused_restart = restart_i;
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(CLK_PER_US);
      localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (restart_i)          cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + CW'(1);
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
      end

      assign tick_o = (cnt_q == LAST) && !restart_i;

      // A restart realigns the microsecond grid: no tick on the next cycle.
      assert_restart_aligns_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/ivt_period_cnt.sv
module ivt_period_cnt #(
  parameter int unsigned         PER_W      = 20,
  parameter logic [PER_W-1:0]    RST_PERIOD = PER_W'(1000)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  output logic             expire_o
);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             last_us;

  assign last_us = (cnt_q == (per_q - PER_W'(1)));

  always_comb begin
    cnt_d    = cnt_q;
    per_d    = per_q;
    expire_o = 1'b0;
    if (restart_i) begin
      cnt_d = '0;
      per_d = period_i;
    end else if (tick_i) begin
      if (last_us) begin
        cnt_d    = '0;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_q + PER_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= RST_PERIOD;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  assert_count_below_period_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < per_q);

  assert_wrap_after_expire_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0));

  assert_restart_loads_period_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0) && (per_q == $past(period_i)));

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 50,
  parameter int unsigned US_PER_SEC = 1000000,
  parameter int unsigned EVENTS_NUM = 1000,
  parameter int unsigned ADDR_W     = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);

  localparam int unsigned       PER_W       = $clog2(US_PER_SEC + 1);
  localparam logic [ADDR_W-1:0] RELOAD_A    = ADDR_W'(OFS_RELOAD);
  localparam logic [ADDR_W-1:0] ACK_A       = ADDR_W'(OFS_ACK_COUNT);
  localparam logic [PER_W-1:0]  RST_PERIOD  =
    PER_W'(ivt_period_us('0, EVENTS_NUM, US_PER_SEC));

  logic             rst_sync_n;
  logic             reload_wr;
  logic             ack_rd;
  logic             tick;
  logic             expire;
  logic [PER_W-1:0] new_period;
  logic             irq_q, irq_d;
  logic             unused_bits;

  ivt_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  // Word decode: bits 1:0 of the address take no part.
  assign reload_wr = bus_sel_i &&  bus_we_i && (bus_addr_i[ADDR_W-1:2] == RELOAD_A[ADDR_W-1:2]);
  assign ack_rd    = bus_sel_i && !bus_we_i && (bus_addr_i[ADDR_W-1:2] == ACK_A[ADDR_W-1:2]);
  assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[31:RELOAD_W]};

  assign new_period = PER_W'(ivt_period_us(bus_wdata_i[RELOAD_W-1:0], EVENTS_NUM, US_PER_SEC));

  ivt_prescaler #(
    .CLK_PER_US (CLK_PER_US)
  ) u_prescaler (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .restart_i (reload_wr),
    .tick_o    (tick)
  );

  ivt_period_cnt #(
    .PER_W      (PER_W),
    .RST_PERIOD (RST_PERIOD)
  ) u_period_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .restart_i (reload_wr),
    .tick_i    (tick),
    .period_i  (new_period),
    .expire_o  (expire)
  );

  // Priority: reload write, then expiry, then acknowledge.
  always_comb begin
    irq_d = irq_q;
    if (reload_wr)   irq_d = 1'b0;
    else if (expire) irq_d = 1'b1;
    else if (ack_rd) irq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_o       = irq_q;
  assign bus_rdata_o = '0;

  assert_reload_drops_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    reload_wr |=> !irq_o);

  assert_expiry_raises_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (expire && !reload_wr) |=> irq_o);

  assert_irq_rise_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(irq_o) |-> $past(expire));

  assert_ack_clears_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (ack_rd && !expire && !reload_wr) |=> !irq_o);

  assert_expiry_beats_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (ack_rd && expire && !reload_wr) |=> irq_o);

endmodule

// File: tb/ivt_timer_tb_top.sv
module ivt_timer_tb_top;

  localparam int CLK_HALF   = 5;
  localparam int CLK_PERIOD = 2 * CLK_HALF;
  localparam int P_CLK_US   = 2;
  localparam int P_US_SEC   = 10000;
  localparam int P_EV_NUM   = 1000;
  localparam int P_ADDR_W   = 14;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                sel;
  logic                we;
  logic [P_ADDR_W-1:0] addr;
  logic [31:0]         wdata;
  logic [31:0]         rdata;
  logic                irq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic irq_prev = 1'b0;
  int exp_q[$];
  bit done = 1'b0;

  always #(CLK_HALF) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ivt_timer #(
    .CLK_PER_US (P_CLK_US),
    .US_PER_SEC (P_US_SEC),
    .EVENTS_NUM (P_EV_NUM),
    .ADDR_W     (P_ADDR_W)
  ) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_sel_i   (sel),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  // Period in clocks taken from the rate formula of R3.
  function automatic int exp_clk(input int r);
    int rate;
    rate = P_EV_NUM / (r + 1);
    return P_CLK_US * (P_US_SEC / rate);
  endfunction

  // Monitor: every rising edge of irq must match the next expected cycle.
  always @(negedge clk) begin
    if (irq === 1'b1 && irq_prev !== 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected irq rise", cyc, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R5", "irq rise cycle", cyc, e);
      end
    end
    irq_prev = irq;
  end

  task automatic bus_write(input logic [P_ADDR_W-1:0] a, input logic [31:0] d, output int w);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    w = cyc + 1;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [P_ADDR_W-1:0] a, output logic [31:0] rd);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 rd = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (irq !== 1'b1 && n < 30000) begin
      @(negedge clk);
      n++;
    end
    check(irq === 1'b1, req, "irq never rose", irq, 1);
  endtask

  task automatic ack(input string req);
    logic [31:0] rd;
    bus_read(P_ADDR_W'(32'h230), rd);
    check(rd == 32'd0, "R6", "count read data", rd, 0);
    check(irq == 1'b0, "R6", {"irq after acknowledge ", req}, irq, 0);
  endtask

  task automatic reload_and_run(input logic [P_ADDR_W-1:0] a, input logic [31:0] d,
                                input int r, input int n, input string req);
    int w, p;
    p = exp_clk(r);
    bus_write(a, d, w);
    check(irq == 1'b0, "R4", "irq after reload write", irq, 0);
    for (int k = 1; k <= n; k++) exp_q.push_back(w + k * p);
    for (int k = 1; k <= n; k++) begin
      wait_irq(req);
      ack(req);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not finish", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w, k;
    logic [31:0] rd;
    rst_n = 1'b0; sel = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(irq == 1'b0, "R8", "irq during reset", irq, 0);
    check(rdata == 32'd0, "R8", "read data during reset", rdata, 0);
    k = cyc;
    exp_q.push_back(k + 2 + exp_clk(0));   // R8: default reload 0, two sync stages
    rst_n = 1'b1;
    @(negedge clk);
    check(irq == 1'b0, "R8", "irq just after release", irq, 0);
    wait_irq("R8");
    ack("R8");

    // R5 and R3: free-running periods with reload 1
    reload_and_run(P_ADDR_W'(32'h228), 32'd1, 1, 3, "R5");
    // R1 and R2: upper bits dropped, byte offset ignored
    reload_and_run(P_ADDR_W'(32'h22B), 32'hFFFF_FE02, 2, 1, "R1 R2");
    // R3: truncation at reload 6 (rate 142, 70 us)
    reload_and_run(P_ADDR_W'(32'h228), 32'd6, 6, 2, "R3");

    // R9: other offsets have no effect
    bus_write(P_ADDR_W'(32'h228), 32'd0, w);
    exp_q.push_back(w + exp_clk(0));
    exp_q.push_back(w + 2 * exp_clk(0));
    wait_irq("R9");
    bus_read(P_ADDR_W'(32'h234), rd);
    check(rd == 32'd0, "R9", "read data at other offset", rd, 0);
    check(irq == 1'b1, "R9", "irq after read of other offset", irq, 1);
    bus_write(P_ADDR_W'(32'h22C), 32'd5, k);
    check(irq == 1'b1, "R9", "irq after write to other offset", irq, 1);
    ack("R9");
    wait_irq("R9");   // second rise keeps the reload-0 period
    // irq left high: the next reload write must drop it (R4)
    reload_and_run(P_ADDR_W'(32'h228), 32'd499, 499, 1, "R3 reload 499");

    // R4: restart in mid-period discards the old schedule
    bus_write(P_ADDR_W'(32'h228), 32'd1, w);
    repeat (25) @(negedge clk);
    check(irq == 1'b0, "R4", "irq before old period ends", irq, 0);
    reload_and_run(P_ADDR_W'(32'h228), 32'd0, 0, 1, "R4");

    // R7: acknowledge on the expiry edge
    bus_write(P_ADDR_W'(32'h228), 32'd0, w);
    exp_q.push_back(w + exp_clk(0));
    while (cyc < w + exp_clk(0) - 1) @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = P_ADDR_W'(32'h230);
    @(negedge clk);
    sel = 1'b0;
    check(irq == 1'b1, "R7", "irq after ack on expiry edge", irq, 1);
    ack("R7");

    // R3: longest period, rate truncates to 1
    reload_and_run(P_ADDR_W'(32'h228), 32'd511, 511, 1, "R3 reload 511");

    check(exp_q.size() == 0, "R5", "expected rises left over", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule